// File: doc/BRIEF.md
# Standby Wake-Up Controller

This block sits beside a processor core and decides when the core, parked in one of its two standby states, has to go back to normal execution. The core asks to sleep with a one-cycle request and a flag naming the kind of standby: interrupt-wait or event-wait. Once it has accepted the request, the block raises a standby flag. It then watches the interrupt, fast-interrupt, asynchronous-abort, debug, event and cluster-broadcast sources, and issues a one-cycle wake pulse when the rules for the current standby kind are met.

The two kinds look at the same request lines but apply them differently. Interrupt-wait ignores the core's three mask bits. Event-wait obeys those mask bits and also wakes on the external event pin or on a send-event pulse from any core in the cluster. Event-type sources are held in a sticky flag. An event that arrives before an event-wait request therefore makes that request return at once without sleeping. Requests that come from outside the clock domain pass through a two-flop synchroniser before they are used. Only this block needs a clock while the core is asleep.

Top module: `stby_wake_ctl`

## Requirements
- R1: After reset, `wake_o` and `standby_o` are 0 and the sticky event flag is clear.
- R2: A `sleep_req_i` pulse accepted while running sets `standby_o` in the following cycle. A `sleep_req_i` received while `standby_o` is 1 has no effect.
- R3: In interrupt-wait standby (`sleep_kind_i` = 0 at request), a synchronised IRQ, FIQ or asynchronous-abort request wakes the core whatever the values of `mask_irq_i`, `mask_fiq_i` and `mask_abt_i`.
- R4: In event-wait standby (`sleep_kind_i` = 1 at request), IRQ, FIQ and abort wake the core only when their own mask bit is 0.
- R5: A debug request, from the `dbg_req_i` pin or from a `dbg_halt_i` command, wakes the core from either standby kind only while both `dbg_en_i` and `dbg_permit_i` are 1.
- R6: With `CLUSTER_EN` = 1, `maint_i` wakes the core from either standby kind.
- R7: Event-wait standby also ends on the synchronised `evt_i` or on `sev_i`. Neither of these wakes interrupt-wait standby.
- R8: `evt_i` and `sev_i` set a sticky event flag at any time. An event-wait request made while the flag is set clears the flag and leaves `standby_o` at 0. A wake from event-wait also clears the flag.
- R9: `wake_o` is high for exactly one cycle, and `standby_o` falls in that same cycle.
- R10: `irq_i`, `fiq_i`, `abt_i`, `dbg_req_i` and `evt_i` pass through `SYNC_STAGES` (two by default) flops. When one of them rises during standby, `wake_o` rises on the third clock edge after the input changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on clock |
| rst_ni | input | 1 | Active-low reset |
| sleep_req_i | input | 1 | One-cycle standby request from the core |
| sleep_kind_i | input | 1 | 0 = interrupt-wait, 1 = event-wait |
| irq_i | input | 1 | Asynchronous IRQ request |
| fiq_i | input | 1 | Asynchronous FIQ request |
| abt_i | input | 1 | Asynchronous abort request |
| mask_irq_i | input | 1 | IRQ mask bit of the core |
| mask_fiq_i | input | 1 | FIQ mask bit of the core |
| mask_abt_i | input | 1 | Abort mask bit of the core |
| dbg_req_i | input | 1 | Asynchronous external debug request pin |
| dbg_halt_i | input | 1 | Halt command from the debug bus (synchronous) |
| dbg_en_i | input | 1 | Invasive debug enabled |
| dbg_permit_i | input | 1 | Debug event permitted |
| evt_i | input | 1 | Asynchronous external event input |
| sev_i | input | 1 | Send-event pulse from a cluster core (synchronous) |
| maint_i | input | 1 | Cache-maintenance broadcast from another core (synchronous) |
| wake_o | output | 1 | One-cycle wake pulse |
| standby_o | output | 1 | Core is in standby |

## Verification
A sticky event can be set in the same cycle that an event-wait request is taken, and a wake condition can be met in the same cycle that a new event arrives. Both collisions decide whether the flag survives. The bench provokes them on purpose: it pulses `sev_i` together with `sleep_req_i`, and it drives `evt_i` so that its synchronised copy lands in the cycle of an event-wait wake. It then judges the result by whether the next event-wait request sleeps or returns at once. A long seeded random run mixes these cases with masked and unmasked interrupts. A cycle model built from the requirements checks `wake_o` and `standby_o` on every cycle.

// File: rtl/stby_pkg.sv
package stby_pkg;
   typedef enum logic {KIND_IWAIT = 1'b0, KIND_EWAIT = 1'b1} stby_kind_e;
   typedef enum logic {ST_RUN = 1'b0, ST_SLEEP = 1'b1} stby_state_e;
   localparam int ASYNC_W = 5;
   localparam int IDX_IRQ = 0;
   localparam int IDX_FIQ = 1;
   localparam int IDX_ABT = 2;
   localparam int IDX_DBG = 3;
   localparam int IDX_EVT = 4;
endpackage

// File: rtl/stby_sync.sv
module stby_sync #(
   parameter int WIDTH  = 1,
   parameter int STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);
   localparam int LAST = STAGES - 1;

   if (STAGES < 2) begin : g_bad_depth
      $error("stby_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("stby_sync: WIDTH must be positive");
   end

   logic [WIDTH-1:0] chain_q [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni)     chain_q[s] <= '0;
         else if (s == 0) chain_q[s] <= d_i;
         else             chain_q[s] <= chain_q[(s == 0) ? 0 : s-1];
      end
   end

   assign q_o = chain_q[LAST];
endmodule

// File: rtl/stby_evt_latch.sv
module stby_evt_latch (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic set_i,
   input  logic clr_i,
   output logic flag_o
);
   logic flag_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_q <= 1'b0;
      else         flag_q <= (flag_q | set_i) & ~clr_i;
   end

   assign flag_o = flag_q;

   a_r8_clear_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_i |=> !flag_o);
   a_r8_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (set_i && !clr_i) |=> flag_o);
endmodule

// File: rtl/stby_wake_eval.sv
module stby_wake_eval
   import stby_pkg::*;
(
   input  stby_kind_e kind_i,
   input  logic       irq_i,
   input  logic       fiq_i,
   input  logic       abt_i,
   input  logic       mask_irq_i,
   input  logic       mask_fiq_i,
   input  logic       mask_abt_i,
   input  logic       dbg_pin_i,
   input  logic       dbg_halt_i,
   input  logic       dbg_en_i,
   input  logic       dbg_permit_i,
   input  logic       evt_flag_i,
   input  logic       evt_now_i,
   input  logic       sev_i,
   input  logic       maint_i,
   output logic       wake_c_o
);
   logic intr_raw, intr_open, dbg_hit, evt_hit, intr_hit;

   always_comb begin
      intr_raw  = irq_i | fiq_i | abt_i;
      intr_open = (irq_i & ~mask_irq_i) | (fiq_i & ~mask_fiq_i) | (abt_i & ~mask_abt_i);
      intr_hit  = (kind_i == KIND_IWAIT) ? intr_raw : intr_open;
      dbg_hit   = (dbg_pin_i | dbg_halt_i) & dbg_en_i & dbg_permit_i;
      evt_hit   = (kind_i == KIND_EWAIT) & (evt_flag_i | evt_now_i | sev_i);
      wake_c_o  = intr_hit | dbg_hit | evt_hit | maint_i;
   end

   always_comb begin
      if (kind_i == KIND_IWAIT && irq_i)
         a_r3_unmasked_wake: assert (wake_c_o);
      if (!dbg_en_i && !intr_raw && !maint_i && kind_i == KIND_IWAIT)
         a_r5_no_dbg_wake: assert (!wake_c_o);
   end
endmodule

// File: rtl/stby_wake_ctl.sv
module stby_wake_ctl
   import stby_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter bit CLUSTER_EN  = 1'b1
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic sleep_req_i,
   input  logic sleep_kind_i,
   input  logic irq_i,
   input  logic fiq_i,
   input  logic abt_i,
   input  logic mask_irq_i,
   input  logic mask_fiq_i,
   input  logic mask_abt_i,
   input  logic dbg_req_i,
   input  logic dbg_halt_i,
   input  logic dbg_en_i,
   input  logic dbg_permit_i,
   input  logic evt_i,
   input  logic sev_i,
   input  logic maint_i,
   output logic wake_o,
   output logic standby_o
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("stby_wake_ctl: SYNC_STAGES must be at least 2");
   end

   logic [ASYNC_W-1:0] async_raw, async_s;
   logic sev_g, maint_g, evt_set, evt_clr, evt_flag, wake_c;
   stby_state_e state_q, state_d;
   stby_kind_e  kind_q, kind_d, kind_in;
   logic wake_q, wake_d;

   assign async_raw = {evt_i, dbg_req_i, abt_i, fiq_i, irq_i};
   assign kind_in   = stby_kind_e'(sleep_kind_i);

   stby_sync #(.WIDTH(ASYNC_W), .STAGES(SYNC_STAGES)) u_sync (
      .clk_i (clk_i), .rst_ni (rst_ni), .d_i (async_raw), .q_o (async_s));

   if (CLUSTER_EN) begin : g_cluster
      assign sev_g   = sev_i;
      assign maint_g = maint_i;
   end else begin : g_single
      assign sev_g   = 1'b0;
      assign maint_g = 1'b0;
   end

   assign evt_set = async_s[IDX_EVT] | sev_g;

   stby_evt_latch u_evt (
      .clk_i (clk_i), .rst_ni (rst_ni), .set_i (evt_set), .clr_i (evt_clr),
      .flag_o (evt_flag));

   stby_wake_eval u_eval (
      .kind_i (kind_q), .irq_i (async_s[IDX_IRQ]), .fiq_i (async_s[IDX_FIQ]),
      .abt_i (async_s[IDX_ABT]), .mask_irq_i (mask_irq_i), .mask_fiq_i (mask_fiq_i),
      .mask_abt_i (mask_abt_i), .dbg_pin_i (async_s[IDX_DBG]), .dbg_halt_i (dbg_halt_i),
      .dbg_en_i (dbg_en_i), .dbg_permit_i (dbg_permit_i), .evt_flag_i (evt_flag),
      .evt_now_i (async_s[IDX_EVT]), .sev_i (sev_g), .maint_i (maint_g),
      .wake_c_o (wake_c));

   always_comb begin
      state_d = state_q;
      kind_d  = kind_q;
      wake_d  = 1'b0;
      evt_clr = 1'b0;
      if (state_q == ST_RUN) begin
         if (sleep_req_i) begin
            if (kind_in == KIND_EWAIT && evt_flag) begin
               evt_clr = 1'b1;
            end else begin
               state_d = ST_SLEEP;
               kind_d  = kind_in;
            end
         end
      end else if (wake_c) begin
         state_d = ST_RUN;
         wake_d  = 1'b1;
         evt_clr = (kind_q == KIND_EWAIT);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         state_q <= ST_RUN;
         kind_q  <= KIND_IWAIT;
         wake_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         kind_q  <= kind_d;
         wake_q  <= wake_d;
      end
   end

   assign wake_o    = wake_q;
   assign standby_o = (state_q == ST_SLEEP);

   a_r2_entry_follows_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(standby_o) |-> $past(sleep_req_i));
   a_r9_wake_drops_standby: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wake_o) |-> (!standby_o && $past(standby_o)));
   a_r9_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wake_o |=> !wake_o);
   a_r2_hold_in_sleep: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (standby_o && !wake_c) |=> standby_o);
endmodule

// File: tb/stby_wake_ctl_bench.sv
module stby_wake_ctl_bench;
   logic clk = 1'b0, rst_n = 1'b0;
   logic req = 0, kind = 0, irq = 0, fiq = 0, abt = 0, mi = 0, mf = 0, ma = 0;
   logic dpin = 0, dhalt = 0, den = 0, dperm = 0, evt = 0, sev = 0, maint = 0;
   logic wake, stby;
   int checks = 0, errors = 0;
   bit done = 0;

   // model state
   bit [4:0] m_s1, m_s2;
   bit m_sleep, m_kind, m_flag, m_wake;

   always #4 clk = ~clk;

   stby_wake_ctl u_stby_wake_ctl (
      .clk_i (clk), .rst_ni (rst_n), .sleep_req_i (req), .sleep_kind_i (kind),
      .irq_i (irq), .fiq_i (fiq), .abt_i (abt), .mask_irq_i (mi), .mask_fiq_i (mf),
      .mask_abt_i (ma), .dbg_req_i (dpin), .dbg_halt_i (dhalt), .dbg_en_i (den),
      .dbg_permit_i (dperm), .evt_i (evt), .sev_i (sev), .maint_i (maint),
      .wake_o (wake), .standby_o (stby));

   function automatic bit wake_rule(bit k, bit [4:0] s, bit flag);
      bit intr;
      intr = k ? ((s[0] & ~mi) | (s[1] & ~mf) | (s[2] & ~ma)) : (s[0] | s[1] | s[2]);
      return intr | ((s[3] | dhalt) & den & dperm) | maint | (k & (flag | s[4] | sev));
   endfunction

   task automatic step();
      bit clr, nw;
      @(posedge clk);
      if (!rst_n) begin
         m_s1 = 0; m_s2 = 0; m_sleep = 0; m_kind = 0; m_flag = 0; m_wake = 0;
      end else begin
         clr = 0; nw = 0;
         if (!m_sleep) begin
            if (req) begin
               if (kind && m_flag) clr = 1;
               else begin m_sleep = 1; m_kind = kind; end
            end
         end else if (wake_rule(m_kind, m_s2, m_flag)) begin
            m_sleep = 0; nw = 1; clr = m_kind;
         end
         m_flag = (m_flag | m_s2[4] | sev) & ~clr;
         m_wake = nw;
         m_s2 = m_s1;
         m_s1 = {evt, dpin, abt, fiq, irq};
      end
      @(negedge clk);
   endtask

   task automatic check(string tag);
      checks++;
      if (wake !== m_wake || stby !== m_sleep) begin
         errors++;
         $display("FAIL %s: wake=%b standby=%b expected wake=%b standby=%b",
                  tag, wake, stby, m_wake, m_sleep);
      end
   endtask

   task automatic expect_bits(string tag, logic w, logic s);
      checks++;
      if (wake !== w || stby !== s) begin
         errors++;
         $display("FAIL %s: wake=%b standby=%b expected wake=%b standby=%b",
                  tag, wake, stby, w, s);
      end
   endtask

   task automatic quiet();
      req = 0; irq = 0; fiq = 0; abt = 0; mi = 0; mf = 0; ma = 0;
      dpin = 0; dhalt = 0; den = 0; dperm = 0; evt = 0; sev = 0; maint = 0;
   endtask

   task automatic sleep(bit k);
      req = 1; kind = k; step(); req = 0;
   endtask

   task automatic run(int n, string tag);
      for (int i = 0; i < n; i++) begin step(); check(tag); end
   endtask

   initial begin
      #400000;
      errors++; checks++;
      $display("FAIL watchdog: run did not end, expected completion");
      done = 1;
   end

   initial begin
      int unsigned seed;
      seed = 32'h5eed_1234;
      void'($urandom(seed));
      quiet();
      step(); step();
      expect_bits("R1", 1'b0, 1'b0);
      rst_n = 1; step(); check("R1");

      // R2 entry and R10 synchroniser latency, R3 masks ignored
      sleep(0); expect_bits("R2", 1'b0, 1'b1);
      mi = 1; mf = 1; ma = 1; irq = 1;
      step(); expect_bits("R10", 1'b0, 1'b1);
      step(); expect_bits("R10", 1'b0, 1'b1);
      step(); expect_bits("R10", 1'b1, 1'b0); check("R3");
      step(); expect_bits("R9", 1'b0, 1'b0);
      irq = 0; run(3, "R3");

      // R4 masked interrupts in event-wait
      sleep(1); check("R2");
      mi = 1; mf = 1; ma = 1; irq = 1; fiq = 1; abt = 1; run(5, "R4");
      req = 1; kind = 0; run(1, "R2"); req = 0;
      mf = 0; run(2, "R4"); quiet(); run(3, "R4");

      // R5 debug qualifiers
      sleep(0); dhalt = 1; den = 1; run(3, "R5");
      dperm = 1; run(2, "R5"); quiet(); run(2, "R5");
      sleep(1); dpin = 1; den = 1; dperm = 1; run(5, "R5"); quiet(); run(3, "R5");

      // R6 maintenance broadcast
      sleep(0); maint = 1; run(2, "R6"); quiet();
      sleep(1); maint = 1; run(2, "R6"); quiet(); run(2, "R6");

      // R7 events wake only event-wait
      sleep(0); sev = 1; run(1, "R7"); sev = 0; evt = 1; run(4, "R7"); evt = 0; run(3, "R7");
      irq = 1; run(4, "R7"); irq = 0; run(3, "R7");
      // flag now set (from above): R8 event-wait returns immediately
      sleep(1); expect_bits("R8", 1'b0, 1'b0);
      sleep(1); expect_bits("R8", 1'b0, 1'b1);
      sev = 1; run(1, "R7"); sev = 0; run(3, "R7");
      // R8 collision: sev with request
      sev = 1; sleep(1); sev = 0; check("R8"); run(3, "R8");
      sleep(1); check("R8"); run(2, "R8");

      // random mix: R3 R4 R5 R6 R7 R8 R9
      for (int i = 0; i < 6000; i++) begin
         req   = ($urandom % 5) == 0;
         kind  = $urandom % 2;
         irq   = ($urandom % 12) == 0; fiq = ($urandom % 14) == 0;
         abt   = ($urandom % 16) == 0;
         mi    = $urandom % 2; mf = $urandom % 2; ma = $urandom % 2;
         dpin  = ($urandom % 20) == 0; dhalt = ($urandom % 20) == 0;
         den   = $urandom % 2; dperm = $urandom % 2;
         evt   = ($urandom % 15) == 0; sev = ($urandom % 18) == 0;
         maint = ($urandom % 30) == 0;
         step(); check("R3 R4 R5 R6 R7 R8 R9 random");
      end
      done = 1;
   end

   initial begin
      wait (done);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule